// File: doc/BRIEF.md
# Three-Level DMA Address Walker

This block produces the source and destination byte addresses for one DMA transfer. The transfer is laid out in three levels. An array is a run of contiguous bytes. A frame is a group of arrays. A block is a group of frames. A parameter set is loaded in a single cycle. After that, synchronization events advance the walk, and each step puts out one array request: a source address, a destination address, the byte count and the access width. The block does not move any data. A separate engine takes the requests and performs the reads and writes.

The source side and the destination side each have two signed 16-bit strides. One applies between arrays inside a frame. The other applies between frames. Either side can be held at a fixed address, which suits a peripheral FIFO; zero strides give the same effect. There are two event granularities. In array mode one event releases one array. In frame mode one event releases a whole frame, issued back to back. After the final array of the final frame, the walker raises a completion pulse and goes idle.

Top module: `dma3d_seq`

## Requirements
- R1: After synchronous reset, `req_valid`, `done`, `evt_err` and `busy` are all 0.
- R2: A `load` pulse latches a parameter set. The count word carries BCNT in bits 31:16 and ACNT in bits 15:0. Each stride word carries the destination stride in bits 31:16 and the source stride in bits 15:0. After the load, `busy` is 1 and every request carries `req_bytes` equal to ACNT.
- R3: In array mode (`ld_frame_sync`=0), an event sampled while the walker is waiting produces exactly one request, with `req_valid` high in the cycle after the event is sampled.
- R4: Between arrays in a frame, each unfixed address moves by its array stride, read as a two's-complement 16-bit value sign-extended to the address width, so negative strides move the address downward.
- R5: In array mode, the first array of a new frame starts at the start of the previous frame's last array plus the frame stride. Every frame after the first holds the reload count instead of BCNT.
- R6: In frame mode (`ld_frame_sync`=1), one event produces BCNT requests in consecutive cycles. The next frame starts at the start of the previous frame plus the frame stride. Every frame holds BCNT arrays.
- R7: A side whose fixed flag is set keeps its loaded base address on every request. `req_width` always equals the 3-bit width field that was loaded.
- R8: With both strides of a side at zero, that side repeats its base address on every request.
- R9: `done` pulses once, in the same cycle as the final request of the final frame. In that cycle `busy` is already 0.
- R10: An event sampled while idle, or while a frame-mode burst is in progress, produces no request and raises `evt_err` for one cycle. A burst already in progress runs on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Latch the parameter set and arm the walker |
| ld_src | input | 32 | Source base address |
| ld_dst | input | 32 | Destination base address |
| ld_cnt | input | 32 | BCNT in bits 31:16, ACNT in bits 15:0 |
| ld_ccnt | input | 16 | Frames per block |
| ld_brld | input | 16 | Arrays per frame for frames after the first (array mode) |
| ld_bidx | input | 32 | Array strides: destination in 31:16, source in 15:0 |
| ld_cidx | input | 32 | Frame strides: destination in 31:16, source in 15:0 |
| ld_frame_sync | input | 1 | 1 = one event per frame, 0 = one event per array |
| ld_src_fixed | input | 1 | Hold the source address constant |
| ld_dst_fixed | input | 1 | Hold the destination address constant |
| ld_width | input | 3 | Access width code passed through to requests |
| evt | input | 1 | Synchronization event |
| busy | output | 1 | A parameter set is loaded and not yet finished |
| req_valid | output | 1 | One array request this cycle |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_bytes | output | 16 | Bytes in the array |
| req_width | output | 3 | Access width code |
| done | output | 1 | Final request of the block |
| evt_err | output | 1 | An event was ignored |

## Verification
The bound checker checks several rules on every cycle: completion coincides with a request while `busy` is low, no request follows an idle cycle that had no load, every error pulse comes from a sampled event, and a fixed side never changes between back-to-back requests. Address values, stride signs, the reload count in array mode, the frame-start rule in each mode and the exact cycle of every request can only be shown by the bench's sweeps. The bench compares each request against an address walk it computes for itself.

// File: rtl/dma3d_pkg.sv
// Package dma3d_pkg
// Shared types for the three-level DMA address walker.
package dma3d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BURST = 2'd2
    } walk_state_t;
endpackage

// File: rtl/dma3d_ctl.sv
// Module dma3d_ctl
// Counts arrays within a frame and frames within a block, and decides when
// an array is issued.
// Assumes: BCNT, CCNT and the reload count are at least one. A load overrides
// any walk in progress.
module dma3d_ctl
    import dma3d_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             evt,
    input  logic             ld_frame_sync,
    input  logic [CNT_W-1:0] ld_bcnt,
    input  logic [CNT_W-1:0] ld_ccnt,
    input  logic [CNT_W-1:0] ld_brld,
    output logic             issue,
    output logic             last_arr,
    output logic             last_blk,
    output logic             frame_mode,
    output logic             busy,
    output logic             evt_bad
);
    walk_state_t      state_q;
    logic [CNT_W-1:0] bleft_q;
    logic [CNT_W-1:0] cleft_q;
    logic [CNT_W-1:0] bcnt_q;
    logic [CNT_W-1:0] brld_q;
    logic             fmode_q;

    // Decode the issue condition and the position in the walk.
    always_comb begin
        issue    = (state_q == ST_BURST) || (state_q == ST_ARMED && evt);
        last_arr = (bleft_q == CNT_W'(1));
        last_blk = last_arr && (cleft_q == CNT_W'(1));
        evt_bad  = evt && (state_q != ST_ARMED) && !load;
        busy     = (state_q != ST_IDLE);
    end

    assign frame_mode = fmode_q;

    // Latch the configuration and step the counters and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bleft_q <= '0;
            cleft_q <= '0;
            bcnt_q  <= '0;
            brld_q  <= '0;
            fmode_q <= 1'b0;
        end else if (load) begin
            state_q <= ST_ARMED;
            bleft_q <= ld_bcnt;
            cleft_q <= ld_ccnt;
            bcnt_q  <= ld_bcnt;
            brld_q  <= ld_brld;
            fmode_q <= ld_frame_sync;
        end else if (issue) begin
            if (!last_arr) begin
                bleft_q <= bleft_q - CNT_W'(1);
                state_q <= fmode_q ? ST_BURST : ST_ARMED;
            end else begin
                bleft_q <= fmode_q ? bcnt_q : brld_q;
                cleft_q <= cleft_q - CNT_W'(1);
                state_q <= last_blk ? ST_IDLE : ST_ARMED;
            end
        end
    end
endmodule

// File: rtl/dma3d_walk.sv
// Module dma3d_walk
// Holds the current array address and the current frame start for one side
// (source or destination) and moves them by signed strides.
// Assumes: ADDR_W > IDX_W. A fixed side never moves.
module dma3d_walk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [IDX_W-1:0]  ld_bstep,
    input  logic [IDX_W-1:0]  ld_cstep,
    input  logic              fixed,
    input  logic              frame_mode,
    input  logic              issue,
    input  logic              last_arr,
    output logic [ADDR_W-1:0] cur
);
    localparam int EXT_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] frm_q;
    logic [ADDR_W-1:0] bstep_q;
    logic [ADDR_W-1:0] cstep_q;
    logic [ADDR_W-1:0] next_frm;

    // Start of the next frame: frame-relative or last-array-relative.
    always_comb begin
        next_frm = (frame_mode ? frm_q : cur_q) + cstep_q;
    end

    // Load the base and the sign-extended strides, then advance on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            frm_q   <= '0;
            bstep_q <= '0;
            cstep_q <= '0;
        end else if (load) begin
            cur_q   <= ld_base;
            frm_q   <= ld_base;
            bstep_q <= {{EXT_W{ld_bstep[IDX_W-1]}}, ld_bstep};
            cstep_q <= {{EXT_W{ld_cstep[IDX_W-1]}}, ld_cstep};
        end else if (issue && !fixed) begin
            if (last_arr) begin
                cur_q <= next_frm;
                frm_q <= next_frm;
            end else begin
                cur_q <= cur_q + bstep_q;
            end
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/dma3d_seq.sv
// Module dma3d_seq
// Top of the three-level DMA address walker. Unpacks the parameter words,
// runs the counter control and one address walker per side, and registers
// the request outputs.
// Assumes: counts are at least one; requests are consumed as issued.
module dma3d_seq
    import dma3d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 16,
    parameter int WID_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [ADDR_W-1:0]    ld_src,
    input  logic [ADDR_W-1:0]    ld_dst,
    input  logic [2*CNT_W-1:0]   ld_cnt,
    input  logic [CNT_W-1:0]     ld_ccnt,
    input  logic [CNT_W-1:0]     ld_brld,
    input  logic [2*IDX_W-1:0]   ld_bidx,
    input  logic [2*IDX_W-1:0]   ld_cidx,
    input  logic                 ld_frame_sync,
    input  logic                 ld_src_fixed,
    input  logic                 ld_dst_fixed,
    input  logic [WID_W-1:0]     ld_width,
    input  logic                 evt,
    output logic                 busy,
    output logic                 req_valid,
    output logic [ADDR_W-1:0]    req_src,
    output logic [ADDR_W-1:0]    req_dst,
    output logic [CNT_W-1:0]     req_bytes,
    output logic [WID_W-1:0]     req_width,
    output logic                 done,
    output logic                 evt_err
);
    logic              issue;
    logic              last_arr;
    logic              last_blk;
    logic              frame_mode;
    logic              evt_bad;
    logic [ADDR_W-1:0] src_cur;
    logic [ADDR_W-1:0] dst_cur;
    logic [CNT_W-1:0]  acnt_q;
    logic [WID_W-1:0]  width_q;
    logic              src_fixed_q;
    logic              dst_fixed_q;

    dma3d_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .evt           (evt),
        .ld_frame_sync (ld_frame_sync),
        .ld_bcnt       (ld_cnt[2*CNT_W-1:CNT_W]),
        .ld_ccnt       (ld_ccnt),
        .ld_brld       (ld_brld),
        .issue         (issue),
        .last_arr      (last_arr),
        .last_blk      (last_blk),
        .frame_mode    (frame_mode),
        .busy          (busy),
        .evt_bad       (evt_bad)
    );

    dma3d_walk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ld_base    (ld_src),
        .ld_bstep   (ld_bidx[IDX_W-1:0]),
        .ld_cstep   (ld_cidx[IDX_W-1:0]),
        .fixed      (src_fixed_q),
        .frame_mode (frame_mode),
        .issue      (issue),
        .last_arr   (last_arr),
        .cur        (src_cur)
    );

    dma3d_walk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ld_base    (ld_dst),
        .ld_bstep   (ld_bidx[2*IDX_W-1:IDX_W]),
        .ld_cstep   (ld_cidx[2*IDX_W-1:IDX_W]),
        .fixed      (dst_fixed_q),
        .frame_mode (frame_mode),
        .issue      (issue),
        .last_arr   (last_arr),
        .cur        (dst_cur)
    );

    // Latch the per-transfer fields that pass straight to the requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acnt_q      <= '0;
            width_q     <= '0;
            src_fixed_q <= 1'b0;
            dst_fixed_q <= 1'b0;
        end else if (load) begin
            acnt_q      <= ld_cnt[CNT_W-1:0];
            width_q     <= ld_width;
            src_fixed_q <= ld_src_fixed;
            dst_fixed_q <= ld_dst_fixed;
        end
    end

    // Register the request, completion and error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_src   <= '0;
            req_dst   <= '0;
            req_bytes <= '0;
            req_width <= '0;
            done      <= 1'b0;
            evt_err   <= 1'b0;
        end else begin
            req_valid <= issue && !load;
            req_src   <= src_cur;
            req_dst   <= dst_cur;
            req_bytes <= acnt_q;
            req_width <= width_q;
            done      <= issue && last_blk && !load;
            evt_err   <= evt_bad;
        end
    end
endmodule

// File: rtl/dma3d_seq_chk.sv
// Module dma3d_seq_chk
// Cycle-level rules for the address walker, bound into dma3d_seq.
module dma3d_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              evt,
    input logic              busy,
    input logic              req_valid,
    input logic              done,
    input logic              evt_err,
    input logic              src_fixed_q,
    input logic              dst_fixed_q,
    input logic [ADDR_W-1:0] req_src,
    input logic [ADDR_W-1:0] req_dst
);
    // R9: completion coincides with the final request
    a_r9_done_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_valid);

    // R9: the walker is already idle when completion is signalled
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: an idle cycle without a load issues nothing next
    a_r10_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> !req_valid);

    // R10: every error pulse comes from a sampled event
    a_r10_err_from_evt: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> $past(evt));

    // R7: a fixed source does not move between back-to-back requests
    a_r7_src_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && src_fixed_q && $past(req_valid) && !$past(load)) |-> $stable(req_src));

    // R7: a fixed destination does not move between back-to-back requests
    a_r7_dst_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dst_fixed_q && $past(req_valid) && !$past(load)) |-> $stable(req_dst));
endmodule

bind dma3d_seq dma3d_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .evt         (evt),
    .busy        (busy),
    .req_valid   (req_valid),
    .done        (done),
    .evt_err     (evt_err),
    .src_fixed_q (src_fixed_q),
    .dst_fixed_q (dst_fixed_q),
    .req_src     (req_src),
    .req_dst     (req_dst)
);

// File: tb/sim_dma3d_seq.sv
module sim_dma3d_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] ld_src = '0, ld_dst = '0, ld_cnt = '0, ld_bidx = '0, ld_cidx = '0;
    logic [15:0] ld_ccnt = '0, ld_brld = '0;
    logic        ld_frame_sync = 1'b0, ld_src_fixed = 1'b0, ld_dst_fixed = 1'b0;
    logic [2:0]  ld_width = '0;
    logic        evt = 1'b0;
    logic        busy, req_valid, done, evt_err;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_bytes;
    logic [2:0]  req_width;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma3d_seq u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_src(ld_src), .ld_dst(ld_dst),
        .ld_cnt(ld_cnt), .ld_ccnt(ld_ccnt), .ld_brld(ld_brld), .ld_bidx(ld_bidx),
        .ld_cidx(ld_cidx), .ld_frame_sync(ld_frame_sync), .ld_src_fixed(ld_src_fixed),
        .ld_dst_fixed(ld_dst_fixed), .ld_width(ld_width), .evt(evt), .busy(busy),
        .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
        .req_bytes(req_bytes), .req_width(req_width), .done(done), .evt_err(evt_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // Compare one request against the model (R3, R4, R7, R8, R9)
    task automatic chk_req(logic [31:0] es, logic [31:0] ed, logic [15:0] acnt,
                           logic [2:0] w, bit last);
        chk("R3 req_valid", 32'(req_valid), 32'd1);
        chk("R4 req_src", req_src, es);
        chk("R4 req_dst", req_dst, ed);
        chk("R2 req_bytes", 32'(req_bytes), 32'(acnt));
        chk("R7 req_width", 32'(req_width), 32'(w));
        chk("R9 done", 32'(done), 32'(last));
        if (last) chk("R9 busy low at done", 32'(busy), 32'd0);
    endtask

    // Run one whole block and check every request against an arithmetic model
    task automatic run_case(int nb, int nc, int nr, bit fm, bit sf, bit df,
                            logic [15:0] sb, logic [15:0] sc,
                            logic [15:0] db, logic [15:0] dc,
                            logic [31:0] sbase, logic [31:0] dbase, logic [2:0] w);
        logic [31:0] es, ed, fs, fd;
        logic [15:0] acnt;
        bit dbl;
        acnt = 16'(nb * 4 + nc);
        @(negedge clk);
        load = 1'b1; ld_src = sbase; ld_dst = dbase;
        ld_cnt = {16'(nb), acnt}; ld_ccnt = 16'(nc); ld_brld = 16'(nr);
        ld_bidx = {db, sb}; ld_cidx = {dc, sc};
        ld_frame_sync = fm; ld_src_fixed = sf; ld_dst_fixed = df; ld_width = w;
        @(negedge clk);
        load = 1'b0;
        chk("R2 busy after load", 32'(busy), 32'd1);
        chk("R2 no request after load", 32'(req_valid), 32'd0);
        es = sbase; ed = dbase; fs = sbase; fd = dbase;
        for (int c = 0; c < nc; c++) begin
            int cnt;
            cnt = (c == 0 || fm) ? nb : nr;
            dbl = fm && (cnt >= 2);
            for (int b = 0; b < cnt; b++) begin
                bit last;
                last = (c == nc - 1) && (b == cnt - 1);
                if (!fm || b == 0) begin
                    evt = 1'b1;
                    @(negedge clk);
                    evt = dbl ? 1'b1 : 1'b0;   // R10: extra event during the burst
                end else begin
                    @(negedge clk);
                    evt = 1'b0;
                    if (b == 1 && dbl) chk("R10 burst event flagged", 32'(evt_err), 32'd1);
                end
                if (fm) chk_req(es, ed, acnt, w, last); else chk_req(es, ed, acnt, w, last);
                if (b < cnt - 1) begin
                    if (!sf) es = es + sx(sb);
                    if (!df) ed = ed + sx(db);
                end else begin
                    if (!sf) begin es = (fm ? fs : es) + sx(sc); fs = es; end
                    if (!df) begin ed = (fm ? fd : ed) + sx(dc); fd = ed; end
                end
            end
            if (!fm) begin
                @(negedge clk);
                chk("R3 one request per event", 32'(req_valid), 32'd0);
            end else if (cnt == 1) begin
                @(negedge clk);
            end
        end
        // After completion: idle, and an event is rejected (R10)
        evt = 1'b0;
        @(negedge clk);
        chk("R9 idle after block", 32'(busy), 32'd0);
        evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
        chk("R10 idle event no request", 32'(req_valid), 32'd0);
        chk("R10 idle event flagged", 32'(evt_err), 32'd1);
        @(negedge clk);
        chk("R10 error is a pulse", 32'(evt_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req_valid", 32'(req_valid), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 evt_err", 32'(evt_err), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        rst_n = 1'b1;
        for (int fm = 0; fm < 2; fm++)
            for (int nb = 1; nb <= 3; nb++)
                for (int nc = 1; nc <= 3; nc++) begin
                    // R4, R5, R6: mixed-sign strides on both sides
                    run_case(nb, nc, nb, bit'(fm), 1'b0, 1'b0,
                             16'd4, 16'd100, 16'hFFF8, 16'hFF00,
                             32'h0000_1000, 32'h0008_0000, 3'd2);
                    // R5: reload count differs; R7 fixed source; R8 zero destination strides
                    run_case(nb, nc, 4 - nb, bit'(fm), 1'b1, 1'b0,
                             16'd12, 16'd40, 16'd0, 16'd0,
                             32'h0000_2000, 32'h0004_0000, 3'd5);
                    // R7: fixed destination, negative source strides wrapping below zero
                    run_case(nb, nc, 2, bit'(fm), 1'b0, 1'b1,
                             16'hFFFC, 16'hFFE0, 16'd7, 16'd9,
                             32'h0000_0010, 32'hF000_0000, 3'd7);
                end
        finished = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule